// File: doc/BRIEF.md
# Multi-Width Parallel Result Port

This block places an 18-bit conversion result on a host data bus whose width is picked at run time: all 18 bits at once, a 16-bit word followed by a 2-bit remainder, or three byte-wide reads. A two-bit mode input selects the width. The fourth mode code hands the pins to a serial port, and in that mode this block drives nothing. The conversion controller passes in the latched result together with a one-cycle data-ready strobe. The port captures the word on that strobe and keeps it until the next strobe, so the host always reads a steady value.

Three of the lowest data pins change role with the mode. In the narrower modes, pin 0 becomes a coding select: high gives straight binary, and low inverts the MSB to give two's complement. Pin 1 becomes address bit A0 in the 16-bit and byte modes, and pin 2 becomes address bit A1 in byte mode. Each pin has its own data and output-enable line. The enable is high only while chip select and read are both low and the pin is an output in the current mode. Pad behaviour lies outside the block.

Top module: `prp_parallel_port`

## Requirements
- R1: The held result loads `result_i` on the clock edge where `ready_i` is high, and it changes on no other edge. A change on `result_i` while `ready_i` is low has no effect on `bus_o`.
- R2: `bus_oe_o` is all zero whenever `cs_n_i` or `rd_n_i` is high.
- R3: Mode code 2'b11 (serial) drives `bus_oe_o` and `bus_o` to all zero.
- R4: Mode code 2'b00 (18-bit) gives `bus_o` equal to the held result in straight binary, whatever the value of `pin_in_i[0]`. While enabled, all 18 bits of `bus_oe_o` are high.
- R5: Bits 0 and 1 are inputs in modes 2'b01 and 2'b10, and bit 2 is an input in mode 2'b10. An input pin has its `bus_oe_o` bit at 0 and its `bus_o` bit at 0. Bits 3 and 14 to 17 are driven in every non-serial mode while enabled.
- R6: In modes 2'b01 and 2'b10, `pin_in_i[0]` low inverts bit 17 of the held result before slicing, and high leaves it unchanged.
- R7: In mode 2'b01 with A0 (`pin_in_i[1]`) low, `bus_o[17:2]` carries result bits 17..2.
- R8: In mode 2'b01 with A0 high, `bus_o[3:2]` carries result bits 1..0 and `bus_o[17:4]` is zero.
- R9: In mode 2'b10, {A1,A0} = {`pin_in_i[2]`,`pin_in_i[1]`} selects what appears on `bus_o[17:10]`: 00 gives result bits 17..10, 01 gives bits 9..2, and 1x gives bits 1..0 on `bus_o[11:10]` with the rest zero. `bus_o[9:3]` is driven zero.
- R10: After reset the held result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| result_i | input | 18 | Result word from the conversion controller |
| ready_i | input | 1 | Data-ready strobe, one cycle |
| mode_i | input | 2 | Interface width code |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read, active low |
| pin_in_i | input | 3 | Input values of data pins 0..2 |
| bus_o | output | 18 | Data pin output values |
| bus_oe_o | output | 18 | Per-pin output enable |

## Verification
The bench walks every mode, address and coding combination against results whose MSB and low bits are distinctive. A slicer with the wrong bit order, or a byte mode that sends the remainder to the wrong pins, shows up as shifted data. Two's-complement coding must appear only in the narrow modes: a design that also inverts in 18-bit mode, or that inverts after slicing, corrupts the top bit of the wrong read. Each mode is checked with chip select and read held high separately and together, because a port that gates on only one of them would drive a bus it does not own. The bench also changes `result_i` with no strobe, because a port that is transparent to its input would tear a word in the middle of a read.

// File: rtl/prp_pkg.sv
package prp_pkg;
  typedef enum logic [1:0] {
    PM_FULL   = 2'b00,
    PM_WORD   = 2'b01,
    PM_BYTE   = 2'b10,
    PM_SERIAL = 2'b11
  } port_mode_e;

  localparam int PIN_FMT = 0;
  localparam int PIN_A0  = 1;
  localparam int PIN_A1  = 2;
  localparam int N_LOW_IN = 3;
endpackage

// File: rtl/prp_result_hold.sv
module prp_result_hold #(
  parameter int RES_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_i,
  input  logic [RES_W-1:0] result_i,
  output logic [RES_W-1:0] held_o,
  output logic             capture_o
);
  assign capture_o = ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n)         held_o <= '0;
    else if (capture_o) held_o <= result_i;
  end
endmodule

// File: rtl/prp_formatter.sv
module prp_formatter
  import prp_pkg::*;
#(
  parameter int RES_W  = 18,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0] held_i,
  input  port_mode_e       mode_i,
  input  logic             fmt_bin_i,
  input  logic             a0_i,
  input  logic             a1_i,
  output logic [RES_W-1:0] data_o
);
  localparam int WREM_W = RES_W - WORD_W;
  localparam int WLSB   = RES_W - WORD_W;
  localparam int BLSB   = RES_W - BYTE_W;
  localparam int BREM_W = RES_W - 2*BYTE_W;

  function automatic logic [RES_W-1:0] apply_coding(
    input logic [RES_W-1:0] w, input port_mode_e m, input logic bin);
    logic [RES_W-1:0] r;
    r = w;
    if (m != PM_FULL && !bin) r[RES_W-1] = ~w[RES_W-1];
    return r;
  endfunction

  function automatic logic [RES_W-1:0] slice_word(
    input logic [RES_W-1:0] w, input logic a0);
    logic [RES_W-1:0] r;
    r = '0;
    if (!a0) r[RES_W-1 -: WORD_W] = w[RES_W-1 -: WORD_W];
    else     r[WLSB +: WREM_W]    = w[WREM_W-1:0];
    return r;
  endfunction

  function automatic logic [RES_W-1:0] slice_byte(
    input logic [RES_W-1:0] w, input logic a1, input logic a0);
    logic [RES_W-1:0] r;
    r = '0;
    if (a1)       r[BLSB +: BREM_W] = w[BREM_W-1:0];
    else if (a0)  r[BLSB +: BYTE_W] = w[BLSB-1 -: BYTE_W];
    else          r[BLSB +: BYTE_W] = w[RES_W-1 -: BYTE_W];
    return r;
  endfunction

  logic [RES_W-1:0] coded;

  always_comb begin
    coded = apply_coding(held_i, mode_i, fmt_bin_i);
    unique case (mode_i)
      PM_FULL:   data_o = coded;
      PM_WORD:   data_o = slice_word(coded, a0_i);
      PM_BYTE:   data_o = slice_byte(coded, a1_i, a0_i);
      default:   data_o = '0;
    endcase
  end
endmodule

// File: rtl/prp_drive_ctrl.sv
module prp_drive_ctrl
  import prp_pkg::*;
#(
  parameter int RES_W = 18
) (
  input  port_mode_e       mode_i,
  input  logic             cs_n_i,
  input  logic             rd_n_i,
  input  logic [RES_W-1:0] data_i,
  output logic [RES_W-1:0] bus_o,
  output logic [RES_W-1:0] bus_oe_o,
  output logic             read_en_o
);
  function automatic logic pin_is_out(input port_mode_e m, input int idx);
    case (m)
      PM_FULL:   return 1'b1;
      PM_WORD:   return idx > PIN_A0;
      PM_BYTE:   return idx > PIN_A1;
      default:   return 1'b0;
    endcase
  endfunction

  assign read_en_o = !cs_n_i && !rd_n_i;

  for (genvar i = 0; i < RES_W; i++) begin : g_pin
    logic dir_out;
    assign dir_out     = pin_is_out(mode_i, i);
    assign bus_o[i]    = dir_out & data_i[i];
    assign bus_oe_o[i] = dir_out & read_en_o;
  end
endmodule

// File: rtl/prp_parallel_port.sv
module prp_parallel_port
  import prp_pkg::*;
#(
  parameter int RES_W  = 18,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RES_W-1:0]    result_i,
  input  logic                ready_i,
  input  logic [1:0]          mode_i,
  input  logic                cs_n_i,
  input  logic                rd_n_i,
  input  logic [N_LOW_IN-1:0] pin_in_i,
  output logic [RES_W-1:0]    bus_o,
  output logic [RES_W-1:0]    bus_oe_o
);
  logic [RES_W-1:0] held_w;
  logic [RES_W-1:0] data_w;
  logic             capture_w;
  logic             read_en_w;
  port_mode_e       mode_w;

  assign mode_w = port_mode_e'(mode_i);

  prp_result_hold #(.RES_W(RES_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .result_i(result_i),
    .held_o(held_w), .capture_o(capture_w)
  );

  prp_formatter #(.RES_W(RES_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_fmt (
    .held_i(held_w), .mode_i(mode_w), .fmt_bin_i(pin_in_i[PIN_FMT]),
    .a0_i(pin_in_i[PIN_A0]), .a1_i(pin_in_i[PIN_A1]), .data_o(data_w)
  );

  prp_drive_ctrl #(.RES_W(RES_W)) u_drv (
    .mode_i(mode_w), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .data_i(data_w),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o), .read_en_o(read_en_w)
  );
endmodule

// File: rtl/prp_port_checker.sv
module prp_port_checker #(
  parameter int RES_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RES_W-1:0] result_i,
  input logic             ready_i,
  input logic [1:0]       mode_i,
  input logic             cs_n_i,
  input logic             rd_n_i,
  input logic [2:0]       pin_in_i,
  input logic [RES_W-1:0] bus_o,
  input logic [RES_W-1:0] bus_oe_o,
  input logic [RES_W-1:0] held_w,
  input logic             capture_w
);
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    capture_w |=> held_w == $past(result_i));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> $stable(held_w));
  p_oe_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || rd_n_i) |-> bus_oe_o == '0);
  p_serial_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b11 |-> (bus_oe_o == '0 && bus_o == '0));
  p_full_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b00 |-> bus_o == held_w);
  p_fixed_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b11 && !cs_n_i && !rd_n_i) |-> (bus_oe_o[3] && &bus_oe_o[RES_W-1:RES_W-4]));
  p_low_inputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 2'b10 |-> bus_oe_o[2:0] == 3'b000);
  p_word_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && pin_in_i[1]) |-> bus_o[RES_W-1:4] == '0);
endmodule

bind prp_parallel_port prp_port_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .result_i(result_i), .ready_i(ready_i),
  .mode_i(mode_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .pin_in_i(pin_in_i),
  .bus_o(bus_o), .bus_oe_o(bus_oe_o), .held_w(held_w), .capture_w(capture_w)
);

// File: tb/tb_prp_parallel_port.sv
module tb_prp_parallel_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] result_i = '0;
  logic        ready_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        cs_n_i = 1'b1;
  logic        rd_n_i = 1'b1;
  logic [2:0]  pin_in_i = 3'b000;
  logic [17:0] bus_o, bus_oe_o;

  int tests = 0;
  int fails = 0;
  int m_held = 0;
  bit r1_phase = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prp_parallel_port dut (.*);

  // reference: held word updates only on strobe
  always @(posedge clk) begin
    if (!rst_n) m_held = 0;
    else if (ready_i) m_held = int'(result_i);
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%05h expected=%05h mode=%0d pins=%0d cs_n=%0b rd_n=%0b",
               tag, act, exp, mode_i, pin_in_i, cs_n_i, rd_n_i);
    end
  endtask

  function automatic int exp_bus();
    int w = m_held;
    int sel;
    if (mode_i != 2'b00 && !pin_in_i[0]) w = w ^ (1 << 17);
    case (mode_i)
      2'b00: return w;
      2'b01: return pin_in_i[1] ? (w % 4) * 4 : (w / 4) * 4;
      2'b10: begin
        sel = pin_in_i[2] * 2 + pin_in_i[1];
        if (sel == 0) return (w / 1024) * 1024;
        if (sel == 1) return ((w / 4) % 256) * 1024;
        return (w % 4) * 1024;
      end
      default: return 0;
    endcase
  endfunction

  function automatic int exp_oe();
    if (cs_n_i || rd_n_i) return 0;
    case (mode_i)
      2'b00: return 18'h3FFFF;
      2'b01: return 18'h3FFFC;
      2'b10: return 18'h3FFF8;
      default: return 0;
    endcase
  endfunction

  function automatic string data_tag();
    if (r1_phase) return "R1";
    if (mode_i == 2'b11) return "R3";
    if (mode_i != 2'b00 && !pin_in_i[0]) return "R6";
    if (mode_i == 2'b00) return "R4";
    if (mode_i == 2'b01) return pin_in_i[1] ? "R8" : "R7";
    return "R9";
  endfunction

  function automatic string oe_tag();
    if (mode_i == 2'b11) return "R3";
    if (cs_n_i || rd_n_i) return "R2";
    return "R5";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(data_tag(), int'(bus_o), exp_bus());
      chk(oe_tag(), int'(bus_oe_o), exp_oe());
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic load(logic [17:0] v);
    step(); result_i = v; ready_i = 1'b1;
    step(); ready_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [17:0] vals [6] = '{18'h00000, 18'h3FFFF, 18'h20000, 18'h1FFFF, 18'h2A5A5, 18'h15A5A};
    repeat (3) @(posedge clk);
    #2;
    // R10: held word zero after reset, visible in 18-bit mode
    cs_n_i = 1'b0; rd_n_i = 1'b0;
    #1;
    chk("R10", int'(bus_o), 0);
    rst_n = 1'b1;
    foreach (vals[k]) begin
      load(vals[k]);
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 8; p++)
          for (int e = 0; e < 4; e++) begin
            step();
            mode_i = 2'(m); pin_in_i = 3'(p);
            cs_n_i = e[0]; rd_n_i = e[1];
          end
      // R1: input changes without a strobe are ignored
      step();
      mode_i = 2'b00; cs_n_i = 1'b0; rd_n_i = 1'b0; r1_phase = 1'b1;
      result_i = ~vals[k];
      repeat (3) step();
      r1_phase = 1'b0;
    end
    // R1: explicit read-back after a fresh strobe
    load(18'h12345);
    step(); mode_i = 2'b00; cs_n_i = 1'b0; rd_n_i = 1'b0;
    @(negedge clk); #1;
    chk("R1", int'(bus_o), 18'h12345);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule